// File: doc/BRIEF.md
# Configuration-Space Target Decoder

This block answers configuration cycles on a multiplexed 32-bit address/data bus. During an address phase it samples the command, the IDSEL line and the address. It claims a cycle only when the cycle is a Type 0 configuration read or write to function 0 with IDSEL high. The register number in the address picks one dword out of a sixteen-dword register file. The following data phase either returns that dword or writes it, with each byte qualified by its byte-enable line.

The register file holds read-only identity and class words, a command word, timing bytes, one memory base address, an interrupt word and two scratch dwords that keep their contents through reset. Bit 1 of the command word enables memory space. Once it is set, memory read and memory write cycles are claimed and signalled on a pulse output to the controller logic that owns the memory-mapped space. While it is clear, as after reset, only configuration cycles are answered.

Top module: `cfg_target`

## Requirements
- R1: A configuration read (command 4'hA) or write (4'hB) with IDSEL high, address bits [1:0] = 2'b00 and function bits [10:8] = 0 raises `cfg_hit` for exactly the one cycle after the address phase. With IDSEL low, no cycle is claimed.
- R2: A configuration cycle whose address bits [1:0] are not 2'b00 (Type 1) is not claimed, and a write in such a cycle changes no register.
- R3: A configuration cycle addressed to a function number other than 0 is not claimed, and its write changes no register.
- R4: The register number is address bits [7:2]. In a claimed read, `rd_valid` is high and `rdata` carries the addressed dword in the cycle after the data phase. Dword 0 reads the identity word.
- R5: A register number of 16 or more is still claimed, reads as all zeros, and a write to it changes no implemented register.
- R6: Commands other than 4'h6, 4'h7, 4'hA and 4'hB raise neither `cfg_hit` nor `mem_hit` and return no read data.
- R7: Reset (synchronous, active-low `rst_n`) returns every writable bit outside the scratch dwords to 0, including the command, timing and base address words.
- R8: Dwords 12 and 13 are fully writable scratch words that keep their contents through reset.
- R9: A memory read (4'h6) or memory write (4'h7) raises `mem_hit` one cycle after the address phase only while command bit 1 (dword 1, bit 1) is set. After reset that bit is clear.
- R10: Dword 2 holds revision [7:0], programming interface [15:8], sub-class [23:16] and base class [31:24], and ignores writes.
- R11: In a configuration write, active-low `be_n[k]` = 0 lets byte k (bits 8k+7..8k) be written. A byte with its enable high keeps its old value.
- R12: Only writable bits take data. In dword 1 these are bits 1, 2, 6 and 8. In dword 3 they are bits [15:0]. In dword 4 they are bits [31:10], so the base address reads zero below bit 10. Dword 15 takes writes on bits [7:0] and reads 8'h01 in bits [15:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low bus reset |
| addr_valid | input | 1 | Address phase strobe |
| ad_in | input | 32 | Multiplexed address (address phase) / write data (data phase) |
| cmd | input | 4 | Bus command, sampled in the address phase |
| idsel | input | 1 | Configuration select, sampled in the address phase |
| data_valid | input | 1 | Data phase strobe |
| be_n | input | 4 | Active-low byte enables for the data phase |
| cfg_hit | output | 1 | Configuration cycle claimed |
| mem_hit | output | 1 | Memory cycle claimed, for the memory-space logic |
| rd_valid | output | 1 | Read data valid |
| rdata | output | 32 | Configuration read data |

## Verification
The bench sends configuration cycles whose fields differ in one place from a claimed cycle: the type bits, the function number, IDSEL, the command and a register number past the end of the file. This separates each rejection condition from the others. Writes of all ones and walking byte enables to each kind of dword show the per-bit writable masks apart from the byte qualification. Memory cycles are sent before and after the enable bit is set. A reset between writes to a scratch word and to ordinary words separates the bits that keep their contents from the bits that are cleared.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam logic [3:0] CMD_MEM_RD = 4'h6;
  localparam logic [3:0] CMD_MEM_WR = 4'h7;
  localparam logic [3:0] CMD_CFG_RD = 4'hA;
  localparam logic [3:0] CMD_CFG_WR = 4'hB;
  localparam int         IDX_BITS   = 6;
  localparam int         FN_BITS    = 3;
endpackage

// File: rtl/cfg_decode.sv
module cfg_decode
  import cfg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                addr_valid,
  input  logic [10:0]         ad_lo,
  input  logic [3:0]          cmd,
  input  logic                idsel,
  input  logic                data_valid,
  input  logic                mem_en,
  output logic                cfg_hit,
  output logic                mem_hit,
  output logic                rd_en,
  output logic                wr_en,
  output logic [IDX_BITS-1:0] reg_idx
);
  logic is_cfg, is_mem, cfg_ok;
  logic pend_rd, pend_wr;

  assign is_cfg = (cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR);
  assign is_mem = (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_WR);
  assign cfg_ok = is_cfg && idsel && (ad_lo[1:0] == 2'b00)
                  && (ad_lo[10:8] == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_hit <= 1'b0;
      mem_hit <= 1'b0;
      pend_rd <= 1'b0;
      pend_wr <= 1'b0;
      reg_idx <= '0;
    end else begin
      cfg_hit <= addr_valid && cfg_ok;
      mem_hit <= addr_valid && is_mem && mem_en;
      if (addr_valid) begin
        pend_rd <= cfg_ok && (cmd == CMD_CFG_RD);
        pend_wr <= cfg_ok && (cmd == CMD_CFG_WR);
        reg_idx <= ad_lo[7:2];
      end else if (data_valid) begin
        pend_rd <= 1'b0;
        pend_wr <= 1'b0;
      end
    end
  end

  assign rd_en = data_valid && pend_rd;
  assign wr_en = data_valid && pend_wr;

  // R2
  type1_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && ad_lo[1:0] != 2'b00) |=> !cfg_hit);
  // R3
  other_fn_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && ad_lo[10:8] != 3'd0) |=> !cfg_hit);
  // R6
  bad_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !is_cfg && !is_mem) |=> (!cfg_hit && !mem_hit));
  // R9
  mem_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_hit |-> $past(mem_en));
  // R1
  cfg_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && cmd == CMD_CFG_RD && idsel && ad_lo[1:0] == 2'b00
     && ad_lo[10:8] == 3'd0) |=> cfg_hit);
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_pkg::*;
#(
  parameter int          NUM_DW     = 16,
  parameter logic [31:0] ID_WORD    = 32'h7A31_1D0F,
  parameter logic [31:0] CLASS_WORD = 32'h0180_0002,
  parameter int          BAR_BITS   = 10,
  parameter logic [15:0] STICKY     = 16'h3000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en,
  input  logic                wr_en,
  input  logic [IDX_BITS-1:0] reg_idx,
  input  logic [31:0]         wdata,
  input  logic [3:0]          be_n,
  output logic [31:0]         rdata,
  output logic                rd_valid,
  output logic                mem_en
);
  localparam int IDX_W = $clog2(NUM_DW);

  function automatic logic [31:0] wmask(int i);
    case (i)
      1:       return 32'h0000_0146;
      3:       return 32'h0000_FFFF;
      4:       return ~((32'd1 << BAR_BITS) - 32'd1);
      15:      return 32'h0000_00FF;
      default: return STICKY[i] ? 32'hFFFF_FFFF : 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] fixed_val(int i);
    case (i)
      0:       return ID_WORD;
      2:       return CLASS_WORD;
      15:      return 32'h0000_0100;
      default: return 32'h0;
    endcase
  endfunction

  logic [31:0] view [NUM_DW];
  logic [31:0] byte_mask;
  logic        in_range;

  assign byte_mask = {{8{~be_n[3]}}, {8{~be_n[2]}}, {8{~be_n[1]}}, {8{~be_n[0]}}};
  assign in_range  = (reg_idx < IDX_BITS'(NUM_DW));

  for (genvar g = 0; g < NUM_DW; g++) begin : g_word
    localparam logic [31:0] MASK = wmask(g);
    logic [31:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n && !STICKY[g]) begin
        word_q <= '0;
      end else if (wr_en && reg_idx == IDX_BITS'(g)) begin
        word_q <= (word_q & ~(MASK & byte_mask)) | (wdata & MASK & byte_mask);
      end
    end
    assign view[g] = (fixed_val(g) & ~MASK) | (word_q & MASK);
  end

  assign mem_en = view[1][1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rdata    <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= in_range ? view[reg_idx[IDX_W-1:0]] : 32'h0;
    end
  end

  // R10
  class_word_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_idx == 6'd2) |=> (rdata == CLASS_WORD));
  // R5
  beyond_file_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_idx >= IDX_BITS'(NUM_DW)) |=> (rdata == 32'h0));
  // R4
  read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
endmodule

// File: rtl/cfg_target.sv
module cfg_target
  import cfg_pkg::*;
#(
  parameter int          NUM_DW     = 16,
  parameter logic [31:0] ID_WORD    = 32'h7A31_1D0F,
  parameter logic [31:0] CLASS_WORD = 32'h0180_0002,
  parameter int          BAR_BITS   = 10,
  parameter logic [15:0] STICKY     = 16'h3000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        addr_valid,
  input  logic [31:0] ad_in,
  input  logic [3:0]  cmd,
  input  logic        idsel,
  input  logic        data_valid,
  input  logic [3:0]  be_n,
  output logic        cfg_hit,
  output logic        mem_hit,
  output logic        rd_valid,
  output logic [31:0] rdata
);
  logic                rd_en, wr_en, mem_en;
  logic [IDX_BITS-1:0] reg_idx;

  cfg_decode u_decode (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .ad_lo(ad_in[10:0]),
    .cmd(cmd), .idsel(idsel), .data_valid(data_valid), .mem_en(mem_en),
    .cfg_hit(cfg_hit), .mem_hit(mem_hit), .rd_en(rd_en), .wr_en(wr_en),
    .reg_idx(reg_idx)
  );

  cfg_regfile #(
    .NUM_DW(NUM_DW), .ID_WORD(ID_WORD), .CLASS_WORD(CLASS_WORD),
    .BAR_BITS(BAR_BITS), .STICKY(STICKY)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .reg_idx(reg_idx),
    .wdata(ad_in), .be_n(be_n), .rdata(rdata), .rd_valid(rd_valid),
    .mem_en(mem_en)
  );
endmodule

// File: tb/cfg_target_tb.sv
module cfg_target_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_valid = 1'b0, idsel = 1'b0, data_valid = 1'b0;
  logic [31:0] ad_in = '0;
  logic [3:0]  cmd = '0, be_n = 4'hF;
  logic        cfg_hit, mem_hit, rd_valid;
  logic [31:0] rdata;
  int checks = 0, fails = 0;

  localparam logic [31:0] ID_W = 32'h7A31_1D0F;
  localparam logic [31:0] CL_W = 32'h0180_0002;

  always #5 clk = ~clk;

  cfg_target u_dut (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .ad_in(ad_in),
    .cmd(cmd), .idsel(idsel), .data_valid(data_valid), .be_n(be_n),
    .cfg_hit(cfg_hit), .mem_hit(mem_hit), .rd_valid(rd_valid), .rdata(rdata)
  );

  logic        g_cfg, g_mem, g_rv;
  logic [31:0] g_rd;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] caddr(input int fn, input int rn, input int ty);
    return 32'(((fn & 7) << 8) | ((rn & 63) << 2) | (ty & 3));
  endfunction

  task automatic bus(input logic [3:0] c, input logic [31:0] a, input logic sel,
                     input logic [31:0] d, input logic [3:0] ben);
    @(negedge clk);
    addr_valid = 1'b1; ad_in = a; cmd = c; idsel = sel;
    @(negedge clk);
    g_cfg = cfg_hit; g_mem = mem_hit;
    addr_valid = 1'b0; data_valid = 1'b1; ad_in = d; be_n = ben;
    @(negedge clk);
    g_rv = rd_valid; g_rd = rdata;
    data_valid = 1'b0; be_n = 4'hF; idsel = 1'b0;
  endtask

  task automatic rd(input int rn);
    bus(4'hA, caddr(0, rn, 0), 1'b1, 32'h0, 4'h0);
  endtask

  task automatic wr(input int rn, input logic [31:0] d, input logic [3:0] ben);
    bus(4'hB, caddr(0, rn, 0), 1'b1, d, ben);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    chk("R7 reset cfg_hit", 32'(cfg_hit), 0);
    chk("R7 reset rd_valid", 32'(rd_valid), 0);
    chk("R9 reset mem_hit", 32'(mem_hit), 0);
  endtask

  task automatic t_mem_disabled();
    bus(4'h6, 32'h1000_0000, 1'b0, 0, 4'h0);
    chk("R9 mem rd before enable", 32'(g_mem), 0);
    rd(1);
    chk("R7 command word after reset", g_rd, 32'h0);
  endtask

  task automatic t_identity();
    rd(0);
    chk("R1 cfg_hit on read", 32'(g_cfg), 1);
    chk("R4 rd_valid", 32'(g_rv), 1);
    chk("R4 identity word", g_rd, ID_W);
    @(negedge clk);
    chk("R1 cfg_hit one cycle", 32'(cfg_hit), 0);
  endtask

  task automatic t_class();
    rd(2);
    chk("R10 class word", g_rd, CL_W);
    wr(2, 32'hFFFF_FFFF, 4'h0);
    rd(2);
    chk("R10 class ignores write", g_rd, CL_W);
  endtask

  task automatic t_masks();
    wr(1, 32'hFFFF_FFFF, 4'h0);
    rd(1);
    chk("R12 command mask", g_rd, 32'h0000_0146);
    wr(4, 32'hFFFF_FFFF, 4'h0);
    rd(4);
    chk("R12 base address mask", g_rd, 32'hFFFF_FC00);
    wr(15, 32'hFFFF_FFFF, 4'h0);
    rd(15);
    chk("R12 interrupt word", g_rd, 32'h0000_01FF);
  endtask

  task automatic t_bytes();
    wr(3, 32'hAABB_CCDD, 4'b1110);
    rd(3);
    chk("R11 byte0 only", g_rd, 32'h0000_00DD);
    wr(3, 32'h1122_3344, 4'b1101);
    rd(3);
    chk("R11 byte1 only", g_rd, 32'h0000_33DD);
    wr(12, 32'h1234_5678, 4'b0101);
    rd(12);
    chk("R11 bytes 1 and 3", g_rd, 32'h1200_5600);
  endtask

  task automatic t_range();
    rd(16);
    chk("R5 claimed beyond file", 32'(g_cfg), 1);
    chk("R5 read zero", g_rd, 32'h0);
    rd(63);
    chk("R5 read 63 zero", g_rd, 32'h0);
    wr(17, 32'h0000_0000, 4'h0);
    rd(1);
    chk("R5 write beyond dropped", g_rd, 32'h0000_0146);
  endtask

  task automatic t_rejects();
    bus(4'hB, caddr(0, 3, 1), 1'b1, 32'h0000_FFFF, 4'h0);
    chk("R2 type1 unclaimed", 32'(g_cfg), 0);
    rd(3);
    chk("R2 type1 write dropped", g_rd, 32'h0000_33DD);
    bus(4'hB, caddr(1, 3, 0), 1'b1, 32'h0000_FFFF, 4'h0);
    chk("R3 fn1 unclaimed", 32'(g_cfg), 0);
    rd(3);
    chk("R3 fn1 write dropped", g_rd, 32'h0000_33DD);
    bus(4'hA, caddr(0, 0, 0), 1'b0, 0, 4'h0);
    chk("R1 idsel low unclaimed", 32'(g_cfg), 0);
    bus(4'h2, caddr(0, 0, 0), 1'b1, 0, 4'h0);
    chk("R6 io read no claim", 32'({g_cfg, g_mem}), 0);
    chk("R6 io read no data", 32'(g_rv), 0);
    bus(4'hC, 32'h1000_0000, 1'b0, 0, 4'h0);
    chk("R6 read-multiple no claim", 32'({g_cfg, g_mem}), 0);
  endtask

  task automatic t_mem_enabled();
    bus(4'h6, 32'h1000_0000, 1'b0, 0, 4'h0);
    chk("R9 mem rd claimed", 32'({g_cfg, g_mem}), 1);
    bus(4'h7, 32'h1000_0004, 1'b0, 32'h5, 4'h0);
    chk("R9 mem wr claimed", 32'(g_mem), 1);
    wr(1, 32'h0, 4'h0);
    bus(4'h6, 32'h1000_0000, 1'b0, 0, 4'h0);
    chk("R9 mem off again", 32'(g_mem), 0);
  endtask

  task automatic t_sticky();
    wr(13, 32'hCAFE_F00D, 4'h0);
    wr(1, 32'h2, 4'h0);
    do_reset();
    rd(13);
    chk("R8 scratch 13 kept", g_rd, 32'hCAFE_F00D);
    rd(12);
    chk("R8 scratch 12 kept", g_rd, 32'h1200_5600);
    rd(3);
    chk("R7 timing word cleared", g_rd, 32'h0);
    rd(4);
    chk("R7 base cleared", g_rd, 32'h0);
    rd(1);
    chk("R7 command cleared", g_rd, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_mem_disabled();
    t_identity();
    t_class();
    t_masks();
    t_bytes();
    t_range();
    t_rejects();
    t_mem_enabled();
    wr(1, 32'h2, 4'h0);
    t_sticky();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule